// File: doc/BRIEF.md
# Time-Slot Virtual Bus Scheduler

This block divides network time into 64 numbered slots. Each incoming time-code opens the slot whose number equals the code's 6-bit value. A schedule table maps each slot to an owning virtual bus and to one of five slot types. When a time-code arrives, the block looks up that slot. If the owner has work, the block issues a one-cycle start pulse to a transaction engine. The pulse carries the bus number, the slot type, the transaction group and the slot number.

The block keeps per-bus load state. Static buses run in two modes: a single-shot group is consumed by one slot, while a repeating group runs in every owned slot until it is unloaded or the bus is closed. Dynamic buses hold a current group and an optional queued group; after the current group runs, the queued group takes its place. Asynchronous and packet buses start in every owned slot, because their own queues decide what runs.

At each slot boundary the block checks the transaction started in the previous slot. If it is unfinished, or it reported an error, that is a fault. The first fault of a bus is reported. A second fault of the same bus also stops that bus until it is closed. The block also asks for asynchronous queue preparation one slot ahead, and flags time-codes that break the count sequence.

Top module: `slot_sched`

## Requirements
- R1: After reset, start_o, prep_o, seq_err_o, fault_o and halt_o are low, and every table entry is empty. Slot type codes are: 0 empty, 1 static, 2 dynamic, 3 asynchronous, 4 packet.
- R2: start_o rises for one cycle, one clock after the time-code strobe, when the entry at the received value has a non-empty type and its owner may run. In that cycle start_bus_o and start_type_o hold the entry's bus and type, start_slot_o holds the received value, and start_grp_o holds the group. The group is 0 for asynchronous and packet slots. An empty entry gives no start.
- R3: Load operation codes are: 0 single-shot, 1 repeating, 2 unload, 3 dynamic current, 4 dynamic next. A static bus loaded single-shot starts in exactly one owned slot. A repeating static bus starts in every owned slot until it is unloaded. After unload it gives no start.
- R4: A dynamic bus starts with its current group in the next owned slot. If a next group is queued, it then becomes current. Otherwise the bus gives no further start until it is loaded again.
- R5: At a time-code, if the previous slot issued a start and the transaction is unfinished or reported an error, fault_o pulses with fault_bus_o set to that bus. It pulses in the same cycle as the new slot's start. A done_i in the same cycle as the time-code counts as finished.
- R6: A second fault of the same bus also pulses halt_o. From then on that bus gets no start, including in the slot that caused the halt, until the bus is closed.
- R7: When the entry for the slot after the received value (mod 64) is asynchronous, prep_o pulses one clock after the strobe. It carries that slot's bus on prep_bus_o and its number on prep_slot_o.
- R8: Closing a bus empties every table entry owned by it. It also clears the bus's load state, fault history and halt.
- R9: A time-code whose value is not the previous value plus one (mod 64) pulses seq_err_o one clock after the strobe. The slot lookup still uses the received value. The first time-code after reset is never flagged.
- R10: A time-code that arrives in the same cycle as a table write uses the entry as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tc_valid_i | input | 1 | Time-code strobe |
| tc_value_i | input | 6 | Time-code value, equal to the slot number |
| tbl_we_i | input | 1 | Schedule table write |
| tbl_slot_i | input | 6 | Slot to write |
| tbl_type_i | input | 3 | Slot type code |
| tbl_bus_i | input | BUS_W | Owning bus |
| ld_valid_i | input | 1 | Bus load operation strobe |
| ld_bus_i | input | BUS_W | Bus to load |
| ld_op_i | input | 3 | Load operation code |
| ld_grp_i | input | GRP_W | Transaction group identity |
| close_i | input | 1 | Close a bus |
| close_bus_i | input | BUS_W | Bus to close |
| done_i | input | 1 | Started transaction finished |
| err_i | input | 1 | Started transaction reported an error |
| start_o | output | 1 | Start pulse to the transaction engine |
| start_bus_o | output | BUS_W | Bus of the start |
| start_type_o | output | 3 | Slot type of the start |
| start_grp_o | output | GRP_W | Group to run |
| start_slot_o | output | 6 | Slot number of the start |
| prep_o | output | 1 | Asynchronous queue preparation request |
| prep_bus_o | output | BUS_W | Bus to prepare for |
| prep_slot_o | output | 6 | Slot being prepared for |
| seq_err_o | output | 1 | Out-of-sequence time-code |
| fault_o | output | 1 | Fault notification |
| fault_bus_o | output | BUS_W | Faulting bus |
| halt_o | output | 1 | Second-fault notification; bus stopped |

## Verification
Two pairs of functions can land in the same cycle. A table write can coincide with the slot lookup of the same slot. The bench drives the write and the strobe in one cycle, expects no start from the old empty entry, and then expects a start when the next time-code hits that slot. Completion can coincide with the boundary fault check: done_i is raised together with the next strobe, and the scoreboard requires no fault. A second fault must also suppress the start of the halted bus in the slot where the halt occurs.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int SLOT_W    = 6;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef enum logic [2:0] {
    SLOT_EMPTY   = 3'd0,
    SLOT_STATIC  = 3'd1,
    SLOT_DYNAMIC = 3'd2,
    SLOT_ASYNC   = 3'd3,
    SLOT_PACKET  = 3'd4
  } bus_type_e;

  typedef enum logic [2:0] {
    OP_ONCE     = 3'd0,
    OP_REPEAT   = 3'd1,
    OP_UNLOAD   = 3'd2,
    OP_DYN_CUR  = 3'd3,
    OP_DYN_NEXT = 3'd4
  } load_op_e;
endpackage

// File: rtl/slot_sched_table.sv
module slot_sched_table
  import slot_sched_pkg::*;
#(
  parameter int BUS_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  bus_type_e         wr_type_i,
  input  logic [BUS_W-1:0]  wr_bus_i,
  input  logic              close_i,
  input  logic [BUS_W-1:0]  close_bus_i,
  input  logic [SLOT_W-1:0] rd_a_slot_i,
  output bus_type_e         rd_a_type_o,
  output logic [BUS_W-1:0]  rd_a_bus_o,
  input  logic [SLOT_W-1:0] rd_b_slot_i,
  output bus_type_e         rd_b_type_o,
  output logic [BUS_W-1:0]  rd_b_bus_o
);
  bus_type_e        typ_arr [NUM_SLOTS];
  logic [BUS_W-1:0] bus_arr [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    bus_type_e        t_q;
    logic [BUS_W-1:0] b_q;
    logic             hit_w;

    assign hit_w = we_i && (wr_slot_i == SLOT_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        t_q <= SLOT_EMPTY;
        b_q <= '0;
      end else if (hit_w) begin
        t_q <= wr_type_i;
        b_q <= wr_bus_i;
      end else if (close_i && b_q == close_bus_i) begin
        t_q <= SLOT_EMPTY;
      end
    end

    assign typ_arr[i] = t_q;
    assign bus_arr[i] = b_q;

    // R8: a close frees every slot of the bus
    p_close_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (close_i && b_q == close_bus_i && !hit_w) |=> (t_q == SLOT_EMPTY));
  end

  assign rd_a_type_o = typ_arr[rd_a_slot_i];
  assign rd_a_bus_o  = bus_arr[rd_a_slot_i];
  assign rd_b_type_o = typ_arr[rd_b_slot_i];
  assign rd_b_bus_o  = bus_arr[rd_b_slot_i];
endmodule

// File: rtl/slot_sched_bus.sv
module slot_sched_bus
  import slot_sched_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_type_e        typ_i,
  input  logic             go_i,
  input  logic             ld_v_i,
  input  load_op_e         ld_op_i,
  input  logic [GRP_W-1:0] ld_grp_i,
  input  logic             close_i,
  output logic             issue_o,
  output logic [GRP_W-1:0] grp_o
);
  logic             st_v_q, st_rep_q, cur_v_q, nx_v_q;
  logic [GRP_W-1:0] st_grp_q, cur_grp_q, nx_grp_q;

  always_comb begin
    issue_o = 1'b0;
    grp_o   = '0;
    unique case (typ_i)
      SLOT_STATIC:  begin issue_o = st_v_q;  grp_o = st_grp_q;  end
      SLOT_DYNAMIC: begin issue_o = cur_v_q; grp_o = cur_grp_q; end
      SLOT_ASYNC,
      SLOT_PACKET:  issue_o = 1'b1;
      default:      issue_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v_q    <= 1'b0;
      st_rep_q  <= 1'b0;
      st_grp_q  <= '0;
      cur_v_q   <= 1'b0;
      cur_grp_q <= '0;
      nx_v_q    <= 1'b0;
      nx_grp_q  <= '0;
    end else begin
      // slot consumption first; a load in the same cycle overrides it
      if (go_i) begin
        if (typ_i == SLOT_STATIC && !st_rep_q) st_v_q <= 1'b0;
        if (typ_i == SLOT_DYNAMIC) begin
          if (nx_v_q) begin
            cur_grp_q <= nx_grp_q;
            nx_v_q    <= 1'b0;
          end else begin
            cur_v_q <= 1'b0;
          end
        end
      end
      if (ld_v_i) begin
        unique case (ld_op_i)
          OP_ONCE:     begin st_v_q <= 1'b1; st_rep_q <= 1'b0; st_grp_q <= ld_grp_i; end
          OP_REPEAT:   begin st_v_q <= 1'b1; st_rep_q <= 1'b1; st_grp_q <= ld_grp_i; end
          OP_UNLOAD:   begin st_v_q <= 1'b0; cur_v_q <= 1'b0; nx_v_q <= 1'b0; end
          OP_DYN_CUR:  begin cur_v_q <= 1'b1; cur_grp_q <= ld_grp_i; end
          OP_DYN_NEXT: begin nx_v_q <= 1'b1; nx_grp_q <= ld_grp_i; end
          default: ;
        endcase
      end
      if (close_i) begin
        st_v_q  <= 1'b0;
        cur_v_q <= 1'b0;
        nx_v_q  <= 1'b0;
      end
    end
  end

  // R3: single-shot group consumed by its slot
  p_once_consumed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && typ_i == SLOT_STATIC && !st_rep_q && !ld_v_i && !close_i) |=> !st_v_q);

  // R4: queued group becomes current after the current one runs
  p_handover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && typ_i == SLOT_DYNAMIC && nx_v_q && !ld_v_i && !close_i)
      |=> (cur_v_q && !nx_v_q && cur_grp_q == $past(nx_grp_q)));
endmodule

// File: rtl/slot_sched_fault.sv
module slot_sched_fault #(
  parameter int NUM_BUS = 8,
  localparam int BUS_W  = $clog2(NUM_BUS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tc_i,
  input  logic               done_i,
  input  logic               err_i,
  input  logic               issue_i,
  input  logic [BUS_W-1:0]   issue_bus_i,
  input  logic               close_i,
  input  logic [BUS_W-1:0]   close_bus_i,
  output logic [NUM_BUS-1:0] halt_now_o,
  output logic [NUM_BUS-1:0] halted_o,
  output logic               fault_o,
  output logic [BUS_W-1:0]   fault_bus_o,
  output logic               halt_o
);
  logic               pend_q, done_q, err_q;
  logic [BUS_W-1:0]   pend_bus_q;
  logic [NUM_BUS-1:0] seen_q, halted_q;
  logic               fail_w, second_w;

  assign fail_w   = tc_i && pend_q && (err_q || err_i || !(done_q || done_i));
  assign second_w = fail_w && seen_q[pend_bus_q];

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_halt
    assign halt_now_o[b] = second_w && (pend_bus_q == BUS_W'(b));
  end
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      pend_bus_q  <= '0;
      seen_q      <= '0;
      halted_q    <= '0;
      fault_o     <= 1'b0;
      fault_bus_o <= '0;
      halt_o      <= 1'b0;
    end else begin
      fault_o     <= fail_w;
      fault_bus_o <= pend_bus_q;
      halt_o      <= second_w;
      if (fail_w)   seen_q[pend_bus_q]   <= 1'b1;
      if (second_w) halted_q[pend_bus_q] <= 1'b1;
      if (close_i) begin
        seen_q[close_bus_i]   <= 1'b0;
        halted_q[close_bus_i] <= 1'b0;
      end
      if (tc_i) begin
        pend_q     <= issue_i;
        pend_bus_q <= issue_bus_i;
        done_q     <= 1'b0;
        err_q      <= 1'b0;
      end else begin
        if (done_i)           done_q <= 1'b1;
        if (err_i && pend_q)  err_q  <= 1'b1;
      end
    end
  end

  // R5: a fault only follows a boundary with an outstanding transaction
  p_fault_at_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(tc_i && pend_q));

  // R6: halt is always part of a fault notification
  p_halt_with_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> fault_o);
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_BUS = 8,
  parameter int GRP_W   = 8,
  localparam int BUS_W  = $clog2(NUM_BUS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tc_valid_i,
  input  logic [5:0]       tc_value_i,
  input  logic             tbl_we_i,
  input  logic [5:0]       tbl_slot_i,
  input  logic [2:0]       tbl_type_i,
  input  logic [BUS_W-1:0] tbl_bus_i,
  input  logic             ld_valid_i,
  input  logic [BUS_W-1:0] ld_bus_i,
  input  logic [2:0]       ld_op_i,
  input  logic [GRP_W-1:0] ld_grp_i,
  input  logic             close_i,
  input  logic [BUS_W-1:0] close_bus_i,
  input  logic             done_i,
  input  logic             err_i,
  output logic             start_o,
  output logic [BUS_W-1:0] start_bus_o,
  output logic [2:0]       start_type_o,
  output logic [GRP_W-1:0] start_grp_o,
  output logic [5:0]       start_slot_o,
  output logic             prep_o,
  output logic [BUS_W-1:0] prep_bus_o,
  output logic [5:0]       prep_slot_o,
  output logic             seq_err_o,
  output logic             fault_o,
  output logic [BUS_W-1:0] fault_bus_o,
  output logic             halt_o
);
  bus_type_e          cur_typ_w, nxt_typ_w;
  logic [BUS_W-1:0]   cur_bus_w, nxt_bus_w;
  logic [SLOT_W-1:0]  nxt_slot_w, exp_slot_w;
  logic [NUM_BUS-1:0] iss_w, go_w, halt_now_w, halted_w, halted_eff_w;
  logic [GRP_W-1:0]   grp_w [NUM_BUS];
  logic               can_w;
  logic [SLOT_W-1:0]  last_q;
  logic               have_last_q;

  assign nxt_slot_w = tc_value_i + SLOT_W'(1);
  assign exp_slot_w = last_q + SLOT_W'(1);

  slot_sched_table #(.BUS_W(BUS_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (tbl_we_i),
    .wr_slot_i   (tbl_slot_i),
    .wr_type_i   (bus_type_e'(tbl_type_i)),
    .wr_bus_i    (tbl_bus_i),
    .close_i     (close_i),
    .close_bus_i (close_bus_i),
    .rd_a_slot_i (tc_value_i),
    .rd_a_type_o (cur_typ_w),
    .rd_a_bus_o  (cur_bus_w),
    .rd_b_slot_i (nxt_slot_w),
    .rd_b_type_o (nxt_typ_w),
    .rd_b_bus_o  (nxt_bus_w)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic sel_w;
    assign sel_w = (cur_bus_w == BUS_W'(b));
    assign go_w[b] = can_w && sel_w;
    slot_sched_bus #(.GRP_W(GRP_W)) u_bus (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .typ_i    (sel_w ? cur_typ_w : SLOT_EMPTY),
      .go_i     (go_w[b]),
      .ld_v_i   (ld_valid_i && ld_bus_i == BUS_W'(b)),
      .ld_op_i  (load_op_e'(ld_op_i)),
      .ld_grp_i (ld_grp_i),
      .close_i  (close_i && close_bus_i == BUS_W'(b)),
      .issue_o  (iss_w[b]),
      .grp_o    (grp_w[b])
    );
  end

  assign halted_eff_w = halted_w | halt_now_w;
  assign can_w = tc_valid_i && (cur_typ_w != SLOT_EMPTY)
              && iss_w[cur_bus_w] && !halted_eff_w[cur_bus_w];

  slot_sched_fault #(.NUM_BUS(NUM_BUS)) u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tc_i        (tc_valid_i),
    .done_i      (done_i),
    .err_i       (err_i),
    .issue_i     (can_w),
    .issue_bus_i (cur_bus_w),
    .close_i     (close_i),
    .close_bus_i (close_bus_i),
    .halt_now_o  (halt_now_w),
    .halted_o    (halted_w),
    .fault_o     (fault_o),
    .fault_bus_o (fault_bus_o),
    .halt_o      (halt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o      <= 1'b0;
      start_bus_o  <= '0;
      start_type_o <= '0;
      start_grp_o  <= '0;
      start_slot_o <= '0;
      prep_o       <= 1'b0;
      prep_bus_o   <= '0;
      prep_slot_o  <= '0;
      seq_err_o    <= 1'b0;
      last_q       <= '0;
      have_last_q  <= 1'b0;
    end else begin
      start_o   <= can_w;
      prep_o    <= tc_valid_i && (nxt_typ_w == SLOT_ASYNC);
      seq_err_o <= tc_valid_i && have_last_q && (tc_value_i != exp_slot_w);
      if (tc_valid_i) begin
        start_bus_o  <= cur_bus_w;
        start_type_o <= cur_typ_w;
        start_grp_o  <= grp_w[cur_bus_w];
        start_slot_o <= tc_value_i;
        prep_bus_o   <= nxt_bus_w;
        prep_slot_o  <= nxt_slot_w;
        last_q       <= tc_value_i;
        have_last_q  <= 1'b1;
      end
    end
  end

  // R2: start follows a strobe by one clock
  p_start_after_tc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(tc_valid_i));

  // R6: a halted bus never receives a start
  p_no_start_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !halted_w[start_bus_o]);

  // R7: preparation request follows a strobe by one clock
  p_prep_after_tc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prep_o |-> $past(tc_valid_i));

  // R9: sequence flag only on a strobe
  p_seq_after_tc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $past(tc_valid_i));
endmodule

// File: tb/slot_sched_bench.sv
`timescale 1ns/1ps
module slot_sched_bench;
  localparam int NUM_BUS = 8;
  localparam int GRP_W   = 8;
  localparam int BUS_W   = $clog2(NUM_BUS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tc_valid = 1'b0;
  logic [5:0]       tc_value = '0;
  logic             tbl_we = 1'b0;
  logic [5:0]       tbl_slot = '0;
  logic [2:0]       tbl_type = '0;
  logic [BUS_W-1:0] tbl_bus = '0;
  logic             ld_valid = 1'b0;
  logic [BUS_W-1:0] ld_bus = '0;
  logic [2:0]       ld_op = '0;
  logic [GRP_W-1:0] ld_grp = '0;
  logic             close_v = 1'b0;
  logic [BUS_W-1:0] close_bus = '0;
  logic             done_v = 1'b0;
  logic             err_v = 1'b0;
  logic             start_o;
  logic [BUS_W-1:0] start_bus_o;
  logic [2:0]       start_type_o;
  logic [GRP_W-1:0] start_grp_o;
  logic [5:0]       start_slot_o;
  logic             prep_o;
  logic [BUS_W-1:0] prep_bus_o;
  logic [5:0]       prep_slot_o;
  logic             seq_err_o;
  logic             fault_o;
  logic [BUS_W-1:0] fault_bus_o;
  logic             halt_o;

  always #2.5 clk = ~clk;

  slot_sched #(.NUM_BUS(NUM_BUS), .GRP_W(GRP_W)) u_slot_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .tc_valid_i(tc_valid), .tc_value_i(tc_value),
    .tbl_we_i(tbl_we), .tbl_slot_i(tbl_slot), .tbl_type_i(tbl_type), .tbl_bus_i(tbl_bus),
    .ld_valid_i(ld_valid), .ld_bus_i(ld_bus), .ld_op_i(ld_op), .ld_grp_i(ld_grp),
    .close_i(close_v), .close_bus_i(close_bus),
    .done_i(done_v), .err_i(err_v),
    .start_o(start_o), .start_bus_o(start_bus_o), .start_type_o(start_type_o),
    .start_grp_o(start_grp_o), .start_slot_o(start_slot_o),
    .prep_o(prep_o), .prep_bus_o(prep_bus_o), .prep_slot_o(prep_slot_o),
    .seq_err_o(seq_err_o), .fault_o(fault_o), .fault_bus_o(fault_bus_o), .halt_o(halt_o)
  );

  typedef struct {
    bit st; int bus; int typ; int grp; int slot;
    bit pr; int prbus;
    bit seq; bit flt; int fbus; bit hlt;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   have_last = 0;
  int   last_v = 0;
  logic tc_seen = 1'b0;
  bit   finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit st, int bus, int typ, int grp, bit pr, int prbus,
                              bit flt, int fbus, bit hlt, string tag);
    exp_t e;
    e.st = st; e.bus = bus; e.typ = typ; e.grp = grp; e.slot = 0;
    e.pr = pr; e.prbus = prbus; e.seq = 0;
    e.flt = flt; e.fbus = fbus; e.hlt = hlt; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t none(string tag);
    return mk(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endfunction

  // monitor
  always @(posedge clk) tc_seen <= tc_valid;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tc_seen) begin
        if (q.size() == 0) begin
          chk(0, "R2", "scoreboard empty", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(start_o == e.st, e.tag, "start_o", int'(start_o), int'(e.st));
          if (e.st && start_o) begin
            chk(int'(start_bus_o) == e.bus, e.tag, "start_bus_o", int'(start_bus_o), e.bus);
            chk(int'(start_type_o) == e.typ, e.tag, "start_type_o", int'(start_type_o), e.typ);
            chk(int'(start_grp_o) == e.grp, e.tag, "start_grp_o", int'(start_grp_o), e.grp);
            chk(int'(start_slot_o) == e.slot, e.tag, "start_slot_o", int'(start_slot_o), e.slot);
          end
          chk(prep_o == e.pr, e.tag, "prep_o", int'(prep_o), int'(e.pr));
          if (e.pr && prep_o) begin
            chk(int'(prep_bus_o) == e.prbus, e.tag, "prep_bus_o", int'(prep_bus_o), e.prbus);
            chk(int'(prep_slot_o) == (e.slot + 1) % 64, e.tag, "prep_slot_o",
                int'(prep_slot_o), (e.slot + 1) % 64);
          end
          chk(seq_err_o == e.seq, "R9", {"seq_err_o ", e.tag}, int'(seq_err_o), int'(e.seq));
          chk(fault_o == e.flt, e.tag, "fault_o", int'(fault_o), int'(e.flt));
          if (e.flt && fault_o)
            chk(int'(fault_bus_o) == e.fbus, e.tag, "fault_bus_o", int'(fault_bus_o), e.fbus);
          chk(halt_o == e.hlt, e.tag, "halt_o", int'(halt_o), int'(e.hlt));
        end
      end else if (start_o || prep_o || seq_err_o || fault_o || halt_o) begin
        chk(0, "R2", "pulse without time-code", 1, 0);
      end
    end
  end

  // driver
  task automatic wr_tbl(int slot, int typ, int bus);
    tbl_we = 1; tbl_slot = 6'(slot); tbl_type = 3'(typ); tbl_bus = BUS_W'(bus);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic load(int bus, int op, int grp);
    ld_valid = 1; ld_bus = BUS_W'(bus); ld_op = 3'(op); ld_grp = GRP_W'(grp);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic close_b(int bus);
    close_v = 1; close_bus = BUS_W'(bus);
    @(negedge clk);
    close_v = 0;
  endtask

  task automatic pulse_done(bit e);
    done_v = 1; err_v = e;
    @(negedge clk);
    done_v = 0; err_v = 0;
  endtask

  task automatic send_tc(int v, exp_t e, bit dn);
    e.slot = v;
    e.seq  = have_last && (v != (last_v + 1) % 64);
    have_last = 1;
    last_v = v;
    q.push_back(e);
    tc_valid = 1; tc_value = 6'(v); done_v = dn;
    @(negedge clk);
    tc_valid = 0; done_v = 0; tbl_we = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset
    chk(start_o == 0, "R1", "start_o", int'(start_o), 0);
    chk(fault_o == 0 && halt_o == 0, "R1", "fault/halt", int'(fault_o) + int'(halt_o), 0);
    chk(prep_o == 0 && seq_err_o == 0, "R1", "prep/seq", int'(prep_o) + int'(seq_err_o), 0);
    send_tc(5, none("R1 empty table"), 0);

    wr_tbl(5, 1, 1);  wr_tbl(6, 2, 2);  wr_tbl(8, 3, 3);  wr_tbl(10, 4, 4);
    wr_tbl(11, 1, 1); wr_tbl(63, 2, 2); wr_tbl(0, 1, 5);
    load(1, 0, 'h11); load(2, 3, 'h21); load(2, 4, 'h22); load(5, 1, 'h51);

    send_tc(4,  none("R2 empty slot"), 0);
    send_tc(5,  mk(1, 1, 1, 'h11, 0, 0, 0, 0, 0, "R3 single-shot"), 0); pulse_done(0);
    send_tc(6,  mk(1, 2, 2, 'h21, 0, 0, 0, 0, 0, "R4 current group"), 0); pulse_done(0);
    send_tc(7,  mk(0, 0, 0, 0, 1, 3, 0, 0, 0, "R7 async prep"), 0);
    send_tc(8,  mk(1, 3, 3, 0, 0, 0, 0, 0, 0, "R2 async start"), 0); pulse_done(0);
    send_tc(9,  none("R2 empty slot 9"), 0);
    send_tc(10, mk(1, 4, 4, 0, 0, 0, 0, 0, 0, "R2 packet start"), 0); pulse_done(0);
    send_tc(11, none("R3 single-shot consumed"), 0);
    send_tc(6,  mk(1, 2, 2, 'h22, 0, 0, 0, 0, 0, "R4 R9 handover, out of sequence"), 0); pulse_done(0);
    send_tc(7,  mk(0, 0, 0, 0, 1, 3, 0, 0, 0, "R7 async prep again"), 0);
    send_tc(6,  none("R4 dynamic drained"), 0);
    send_tc(63, none("R4 dynamic idle"), 0);
    send_tc(0,  mk(1, 5, 1, 'h51, 0, 0, 0, 0, 0, "R9 wrap R3 repeat"), 0); pulse_done(0);
    send_tc(1,  none("R2 slot 1 empty"), 0);
    send_tc(0,  mk(1, 5, 1, 'h51, 0, 0, 0, 0, 0, "R3 repeat again"), 0); pulse_done(0);

    // faults
    load(1, 0, 'h12);
    send_tc(5,  mk(1, 1, 1, 'h12, 0, 0, 0, 0, 0, "R5 start then no done"), 0);
    send_tc(6,  mk(0, 0, 0, 0, 0, 0, 1, 1, 0, "R5 first fault"), 0);
    load(1, 0, 'h13);
    send_tc(11, mk(1, 1, 1, 'h13, 0, 0, 0, 0, 0, "R6 still runs after first fault"), 0);
    send_tc(12, mk(0, 0, 0, 0, 0, 0, 1, 1, 1, "R6 second fault halts"), 0);
    load(1, 0, 'h14);
    send_tc(5,  none("R6 halted bus no start"), 0);
    send_tc(6,  none("R5 no pending no fault"), 0);

    // close
    close_b(1);
    load(1, 0, 'h15);
    send_tc(5,  none("R8 slot 5 freed"), 0);
    send_tc(11, none("R8 slot 11 freed"), 0);
    wr_tbl(11, 1, 1);
    send_tc(11, mk(1, 1, 1, 'h15, 0, 0, 0, 0, 0, "R8 halt cleared by close"), 0); pulse_done(0);

    // done coincident with time-code
    send_tc(0,  mk(1, 5, 1, 'h51, 0, 0, 0, 0, 0, "R3 repeat start"), 0);
    send_tc(1,  none("R5 done with time-code no fault"), 1);

    // table write coincident with time-code
    tbl_we = 1; tbl_slot = 6'd2; tbl_type = 3'd1; tbl_bus = BUS_W'(5);
    send_tc(2,  none("R10 old entry used"), 0);
    send_tc(2,  mk(1, 5, 1, 'h51, 0, 0, 0, 0, 0, "R10 new entry later"), 0);
    pulse_done(1);
    send_tc(3,  mk(0, 0, 0, 0, 0, 0, 1, 5, 0, "R5 error reported fault"), 0);

    load(5, 2, 0);
    send_tc(0,  none("R3 unloaded"), 0);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard leftover", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule